// File: doc/BRIEF.md
# Watchdog Timer with Reset Control Register

The block is an 8-bit watchdog timer whose counter advances on each cycle where a prescale tick is high and the timer is running. In interval mode the counter simply wraps. In watchdog mode a wrap from all ones to zero is an overflow. An overflow latches a sticky flag, clears the timer's own counter and timer control register, and can raise a one-cycle internal reset request that carries a reset-type indication for a downstream reset controller.

Software reaches three registers over a simple bus with an address, read and write strobes and a 16-bit write word. Every write must carry a key in its upper byte, and anything else is dropped. The overflow flag cannot be cleared by a stray write. Software must first read the reset control register while the flag is set, and then write 0 to the flag bit. The reset control register is initialised only by the external pin reset. The watchdog's own overflow reset leaves it alone, so software can find out after the restart why the restart happened.

Address map: 0 = timer control (bit 0 run, bit 1 watchdog mode, others read 0); 1 = counter; 2 = reset control (bit 7 overflow flag, bit 6 reset enable, bit 5 reset type, bits 4..0 reserved); 3 reads 0.

Top module: `wdt_reset_ctl`

## Requirements
- R1: While pin_rst_n is low, and after it rises, the reset control register reads 8'h1F, the counter and timer control read 0, and rst_req and rst_type are 0.
- R2: A write takes effect only when bus_wr is 1 and bus_wdata[15:8] equals 8'h5A. The data then comes from bus_wdata[7:0]. Any other write changes no register.
- R3: The counter goes up by one at each clock where tick is 1 and the run bit (timer control bit 0) is 1. Otherwise it holds, unless the counter itself is written.
- R4: In interval mode (timer control bit 1 = 0), a wrap from 8'hFF to 8'h00 leaves the flag at 0, raises no request, and the counter keeps counting.
- R5: In watchdog mode (bit 1 = 1), a wrap from 8'hFF sets the flag, which reads as bit 7 of the reset control register.
- R6: On a watchdog overflow with reset enable (bit 6) at 1, rst_req is high for exactly one cycle, starting the cycle after the overflow edge. In that cycle rst_type equals the type bit (bit 5: 0 = power-on, 1 = manual). With enable at 0 there is no pulse, and rst_type holds its earlier value.
- R7: A watchdog overflow returns the counter and the timer control register to 0 whatever the enable bit is, and it leaves the enable and type bits unchanged.
- R8: The flag clears only on a valid write with bit 7 = 0 that follows a read of address 2 during which the flag was 1. Any valid write to address 2 ends this arming. A write of 0 with no arming read before it, or a write of 1, leaves the flag as it is.
- R9: Reserved bits 4..0 of the reset control register always read as 1, and writes do not change them.
- R10: If a watchdog overflow and an armed flag-clear write fall in the same cycle, the flag stays at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| pin_rst_n | input | 1 | External pin reset, asynchronous, active low |
| tick | input | 1 | Prescaled count enable |
| bus_addr | input | 2 | Register select |
| bus_rd | input | 1 | Read strobe (arms the flag clear) |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 16 | Key in the upper byte, data in the lower byte |
| bus_rdata | output | 8 | Read data for bus_addr (combinational) |
| rst_req | output | 1 | One-cycle internal reset request |
| rst_type | output | 1 | Registered reset type: 0 power-on, 1 manual |

## Verification
The bench aims at the flag-clear handshake. It tries a zero write without an arming read, a one write after an arming read, and a proper read-then-write. A design that skipped the arming latch would clear the flag on the unarmed write, and one that did not disarm would clear it later when no read came first. It places an armed clear write on the exact overflow edge. A design that gave priority to the clear there would lose the flag. It also checks that a wrong key leaves all three registers alone, that interval-mode wraps never set the flag, that the request lasts one cycle and carries the chosen type, and that the self-reset clears the counter while the enable and type survive.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
   typedef enum logic [1:0] {
      SEL_TCTL = 2'd0,
      SEL_CNT  = 2'd1,
      SEL_RCTL = 2'd2,
      SEL_NONE = 2'd3
   } wdt_sel_e;

   typedef struct packed {
      logic wdog;
      logic run;
   } tctl_t;

   // bit positions inside the reset control byte
   localparam int unsigned RC_FLAG = 7;
   localparam int unsigned RC_EN   = 6;
   localparam int unsigned RC_TYP  = 5;
endpackage

// File: rtl/wdt_bus_gate.sv
module wdt_bus_gate
   import wdt_pkg::*;
#(
   parameter int unsigned DW = 8,
   parameter logic [DW-1:0] KEY = 8'h5A
) (
   input  logic          bus_wr,
   input  logic [1:0]    bus_addr,
   input  logic [2*DW-1:0] bus_wdata,
   output logic          wr_tctl,
   output logic          wr_cnt,
   output logic          wr_rctl,
   output logic [DW-1:0] wr_data
);
   logic key_ok;

   generate
      if (DW < 8) begin : g_bad_dw
         $error("wdt_bus_gate: DW must be at least 8");
      end
   endgenerate

   assign key_ok  = bus_wr && (bus_wdata[2*DW-1:DW] == KEY);
   assign wr_data = bus_wdata[DW-1:0];

   always_comb begin
      wr_tctl = 1'b0;
      wr_cnt  = 1'b0;
      wr_rctl = 1'b0;
      if (key_ok) begin
         case (wdt_sel_e'(bus_addr))
            SEL_TCTL: wr_tctl = 1'b1;
            SEL_CNT:  wr_cnt  = 1'b1;
            SEL_RCTL: wr_rctl = 1'b1;
            default:  ;
         endcase
      end
   end
endmodule

// File: rtl/wdt_counter.sv
module wdt_counter
   import wdt_pkg::*;
#(
   parameter int unsigned CW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          tick,
   input  logic          wr_tctl,
   input  tctl_t         wr_tctl_val,
   input  logic          wr_cnt,
   input  logic [CW-1:0] wr_cnt_val,
   output logic [CW-1:0] cnt,
   output tctl_t         tctl,
   output logic          ovf_wd
);
   localparam logic [CW-1:0] CNT_MAX = '1;

   logic step;

   generate
      if (CW < 2) begin : g_bad_cw
         $error("wdt_counter: CW must be at least 2");
      end
   endgenerate

   assign step   = tctl.run && tick;
   assign ovf_wd = step && tctl.wdog && (cnt == CNT_MAX);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt  <= '0;
         tctl <= '0;
      end else if (ovf_wd) begin
         cnt  <= '0;
         tctl <= '0;
      end else begin
         if (wr_tctl) tctl <= wr_tctl_val;
         if (wr_cnt)     cnt <= wr_cnt_val;
         else if (step)  cnt <= cnt + 1'b1;
      end
   end

   AST_SELF_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      ovf_wd |=> (cnt == '0 && !tctl.run && !tctl.wdog)); // R7
   AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (tctl.run && tick && !wr_cnt) |=> (cnt == CW'($past(cnt) + 1'b1))); // R3
   AST_COUNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick && !wr_cnt) |=> $stable(cnt)); // R3
endmodule

// File: rtl/wdt_rctl_reg.sv
module wdt_rctl_reg (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       ovf_wd,
   input  logic       rd_rctl,
   input  logic       wr_rctl,
   input  logic [2:0] wr_bits,   // {flag, enable, type}
   output logic       flag,
   output logic       en,
   output logic       typ,
   output logic       rst_req,
   output logic       rst_type
);
   logic armed;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flag  <= 1'b0;
         armed <= 1'b0;
         en    <= 1'b0;
         typ   <= 1'b0;
      end else begin
         if (ovf_wd)                           flag <= 1'b1;
         else if (wr_rctl && armed && !wr_bits[2]) flag <= 1'b0;

         if (wr_rctl)              armed <= 1'b0;
         else if (rd_rctl && flag) armed <= 1'b1;

         if (wr_rctl) begin
            en  <= wr_bits[1];
            typ <= wr_bits[0];
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rst_req  <= 1'b0;
         rst_type <= 1'b0;
      end else begin
         rst_req <= ovf_wd && en;
         if (ovf_wd && en) rst_type <= typ;
      end
   end

   AST_FLAG_SRC: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flag) |-> $past(ovf_wd)); // R5
   AST_CLR_ARMED: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(flag) |-> $past(armed)); // R8
   AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      ovf_wd |=> flag); // R10
   AST_REQ_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      rst_req |=> !rst_req); // R6
   AST_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_rctl |=> $stable({en, typ})); // R2
endmodule

// File: rtl/wdt_reset_ctl.sv
module wdt_reset_ctl
   import wdt_pkg::*;
#(
   parameter int unsigned DW = 8,
   parameter int unsigned CW = 8,
   parameter logic [DW-1:0] KEY = 8'h5A
) (
   input  logic          clk,
   input  logic          pin_rst_n,
   input  logic          tick,
   input  logic [1:0]    bus_addr,
   input  logic          bus_rd,
   input  logic          bus_wr,
   input  logic [2*DW-1:0] bus_wdata,
   output logic [DW-1:0] bus_rdata,
   output logic          rst_req,
   output logic          rst_type
);
   localparam int unsigned RSV_W = DW - 3;

   logic          wr_tctl, wr_cnt, wr_rctl;
   logic [DW-1:0] wr_data;
   logic [CW-1:0] cnt;
   tctl_t         tctl;
   logic          ovf_wd;
   logic          flag, en, typ;
   logic          rd_rctl;

   generate
      if (CW > DW) begin : g_bad_width
         $error("wdt_reset_ctl: CW must not exceed DW");
      end
   endgenerate

   wdt_bus_gate #(.DW(DW), .KEY(KEY)) u_gate (
      .bus_wr    (bus_wr),
      .bus_addr  (bus_addr),
      .bus_wdata (bus_wdata),
      .wr_tctl   (wr_tctl),
      .wr_cnt    (wr_cnt),
      .wr_rctl   (wr_rctl),
      .wr_data   (wr_data)
   );

   wdt_counter #(.CW(CW)) u_cnt (
      .clk         (clk),
      .rst_n       (pin_rst_n),
      .tick        (tick),
      .wr_tctl     (wr_tctl),
      .wr_tctl_val (tctl_t'(wr_data[1:0])),
      .wr_cnt      (wr_cnt),
      .wr_cnt_val  (wr_data[CW-1:0]),
      .cnt         (cnt),
      .tctl        (tctl),
      .ovf_wd      (ovf_wd)
   );

   assign rd_rctl = bus_rd && (wdt_sel_e'(bus_addr) == SEL_RCTL);

   wdt_rctl_reg u_rctl (
      .clk      (clk),
      .rst_n    (pin_rst_n),
      .ovf_wd   (ovf_wd),
      .rd_rctl  (rd_rctl),
      .wr_rctl  (wr_rctl),
      .wr_bits  (wr_data[RC_FLAG:RC_TYP]),
      .flag     (flag),
      .en       (en),
      .typ      (typ),
      .rst_req  (rst_req),
      .rst_type (rst_type)
   );

   always_comb begin
      case (wdt_sel_e'(bus_addr))
         SEL_TCTL: bus_rdata = {{(DW-2){1'b0}}, tctl.wdog, tctl.run};
         SEL_CNT:  bus_rdata = DW'(cnt);
         SEL_RCTL: bus_rdata = {flag, en, typ, {RSV_W{1'b1}}};
         default:  bus_rdata = '0;
      endcase
   end

   AST_REQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!pin_rst_n)
      rst_req |-> flag); // R6
endmodule

// File: tb/test_wdt_reset_ctl.sv
module test_wdt_reset_ctl;
   logic        clk = 1'b0;
   logic        pin_rst_n = 1'b0;
   logic        tick = 1'b0;
   logic [1:0]  bus_addr = 2'd0;
   logic        bus_rd = 1'b0;
   logic        bus_wr = 1'b0;
   logic [15:0] bus_wdata = 16'h0;
   logic [7:0]  bus_rdata;
   logic        rst_req, rst_type;

   int errors = 0;
   int checks = 0;

   localparam logic [1:0] A_TC = 2'd0, A_CNT = 2'd1, A_RC = 2'd2;
   localparam logic [7:0] KEY = 8'h5A;

   always #5 clk = ~clk;

   wdt_reset_ctl i_wdt_reset_ctl (
      .clk(clk), .pin_rst_n(pin_rst_n), .tick(tick),
      .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .rst_req(rst_req), .rst_type(rst_type)
   );

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // all tasks start and end at a falling edge
   task automatic wr(input logic [1:0] a, input logic [7:0] k, input logic [7:0] d);
      bus_addr = a; bus_wdata = {k, d}; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd_chk(input logic [1:0] a, input logic [7:0] exp, input string req);
      bus_addr = a; bus_rd = 1'b1;
      #1 chk(req, bus_rdata, exp);
      @(negedge clk);
      bus_rd = 1'b0;
   endtask

   // leaves counter at FF, one edge before the overflow
   task automatic run_to_ovf(input logic [7:0] tc);
      tick = 1'b1;
      wr(A_CNT, KEY, 8'hFE);
      wr(A_TC, KEY, tc);
      @(negedge clk);
   endtask

   task automatic t_reset;
      chk("R1 rst_req", rst_req, 0);
      chk("R1 rst_type", rst_type, 0);
      rd_chk(A_RC, 8'h1F, "R1 rctl");
      rd_chk(A_CNT, 8'h00, "R1 cnt");
      rd_chk(A_TC, 8'h00, "R1 tctl");
   endtask

   task automatic t_count;
      wr(A_CNT, KEY, 8'h10);
      wr(A_TC, KEY, 8'h01);
      rd_chk(A_CNT, 8'h10, "R3 hold without tick");
      tick = 1'b1;
      repeat (5) @(negedge clk);
      tick = 1'b0;
      rd_chk(A_CNT, 8'h15, "R3 five ticks");
      wr(A_TC, KEY, 8'h00);
   endtask

   task automatic t_key;
      wr(A_RC, 8'hA5, 8'h60);
      rd_chk(A_RC, 8'h1F, "R2 bad key rctl");
      wr(A_CNT, 8'h00, 8'h33);
      rd_chk(A_CNT, 8'h15, "R2 bad key cnt");
      wr(A_TC, 8'h5B, 8'h03);
      rd_chk(A_TC, 8'h00, "R2 bad key tctl");
   endtask

   task automatic t_reserved;
      wr(A_RC, KEY, 8'h00);
      rd_chk(A_RC, 8'h1F, "R9 reserved stay 1");
      wr(A_RC, KEY, 8'h60);
      rd_chk(A_RC, 8'h7F, "R9 en/typ write");
   endtask

   task automatic t_interval;
      wr(A_RC, KEY, 8'h40);
      run_to_ovf(8'h01);
      @(negedge clk);
      chk("R4 no req", rst_req, 0);
      rd_chk(A_CNT, 8'h00, "R4 wrap");
      tick = 1'b0;
      rd_chk(A_CNT, 8'h01, "R4 keeps counting");
      rd_chk(A_RC, 8'h5F, "R4 flag clear");
      wr(A_TC, KEY, 8'h00);
   endtask

   task automatic t_wdog_por;
      run_to_ovf(8'h03);
      @(negedge clk);
      chk("R6 req pulse", rst_req, 1);
      chk("R6 type por", rst_type, 0);
      tick = 1'b0;
      rd_chk(A_RC, 8'hDF, "R5 flag set");
      chk("R6 single cycle", rst_req, 0);
      rd_chk(A_CNT, 8'h00, "R7 cnt cleared");
      rd_chk(A_TC, 8'h00, "R7 tctl cleared");
   endtask

   task automatic t_clear;
      // armed by the read in t_wdog_por
      wr(A_RC, KEY, 8'hC0);
      wr(A_RC, KEY, 8'h40);
      rd_chk(A_RC, 8'hDF, "R8 no clear without arm");
      wr(A_RC, KEY, 8'h40);
      rd_chk(A_RC, 8'h5F, "R8 clear after read");
   endtask

   task automatic t_wdog_manual;
      wr(A_RC, KEY, 8'h60);
      run_to_ovf(8'h03);
      @(negedge clk);
      chk("R6 req manual", rst_req, 1);
      chk("R6 type manual", rst_type, 1);
      tick = 1'b0;
      rd_chk(A_RC, 8'hFF, "R7 en/typ kept");
      wr(A_RC, KEY, 8'h00);
      rd_chk(A_RC, 8'h1F, "R8 clear and disable");
   endtask

   task automatic t_wdog_noen;
      run_to_ovf(8'h03);
      @(negedge clk);
      chk("R6 no req when disabled", rst_req, 0);
      chk("R6 type held", rst_type, 1);
      tick = 1'b0;
      rd_chk(A_CNT, 8'h00, "R7 cnt cleared without enable");
      rd_chk(A_RC, 8'h9F, "R5 flag without enable");
   endtask

   task automatic t_priority;
      // armed by the read at the end of t_wdog_noen
      run_to_ovf(8'h03);
      wr(A_RC, KEY, 8'h00);
      tick = 1'b0;
      rd_chk(A_RC, 8'h9F, "R10 set wins");
      wr(A_RC, KEY, 8'h00);
      rd_chk(A_RC, 8'h1F, "R10 later clear works");
   endtask

   task automatic t_pin_reset;
      wr(A_RC, KEY, 8'h60);
      wr(A_CNT, KEY, 8'h44);
      pin_rst_n = 1'b0;
      @(negedge clk);
      rd_chk(A_RC, 8'h1F, "R1 rctl during reset");
      pin_rst_n = 1'b1;
      @(negedge clk);
      rd_chk(A_RC, 8'h1F, "R1 rctl after pin reset");
      rd_chk(A_CNT, 8'h00, "R1 cnt after pin reset");
      chk("R1 type after pin reset", rst_type, 0);
   endtask

   initial begin
      fork
         begin
            repeat (3) @(negedge clk);
            pin_rst_n = 1'b1;
            @(negedge clk);
            t_reset();
            t_count();
            t_key();
            t_reserved();
            t_interval();
            t_wdog_por();
            t_clear();
            t_wdog_manual();
            t_wdog_noen();
            t_priority();
            t_pin_reset();
         end
         begin
            repeat (20000) @(posedge clk);
            chk("watchdog timeout", 1, 0);
         end
      join_any
      disable fork;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule